// File: doc/BRIEF.md
# Bus-master DMA channel control registers

This block holds the control registers for one channel of a legacy two-channel disk controller that moves data by bus-master DMA. It has three registers: an 8-bit command register, an 8-bit status register and a 32-bit descriptor table pointer. Software reaches them through a byte-addressed port inside an 8-byte window. Each access is 1, 2 or 4 bytes wide.

When software toggles the start/stop bit of the command register, the block sends a one-cycle start pulse or a one-cycle abort pulse toward the drive-side DMA engine. The start pulse carries the descriptor table pointer. The engine reports the end of a transfer on a completion input. The block then stops the channel and raises its interrupt status, which reaches the interrupt output when the interrupt enable input allows it.

Top module: `bm_chan_regs`

## Requirements
- R1: Reads are little-endian from the addressed byte. The command register is at byte 0, the status register at byte 2 and the pointer at bytes 4..7; bytes 1 and 3 read as zero. Any byte lane beyond byte 7 or beyond the access size reads as zero. Size code 0, 1 and 2 select 1, 2 and 4 bytes.
- R2: After reset the command register and the pointer are zero, the status register is 0x60 (DMA-capable bits 5 and 6 set), and `irq`, `err_flag`, `dma_start` and `dma_abort` are low.
- R3: A command write that takes start/stop (bit 0) from 0 to 1 sets the active bit (status bit 0). In the following cycle `dma_start` is high for one cycle and `dma_start_ptr` holds the pointer.
- R4: A command write that takes start/stop from 1 to 0 clears the active bit. In the following cycle `dma_abort` is high for one cycle.
- R5: While start/stop is 1, a command write cannot change the direction bit (bit 3).
- R6: Status writes never change the active bit.
- R7: The interrupt bit (status bit 2) and the error bit (status bit 1) are cleared only by writing 1 to a bit that is already 1. Writing 0 keeps the bit, and writing 1 cannot set it. Bits 3..7 of status are stored as written.
- R8: A 4-byte write at byte 4 stores the pointer with bits 1:0 forced to zero.
- R9: Only three writes are legal: a 1-byte write at byte 0, a 1-byte write at byte 2, and a 4-byte write at byte 4. Any other write, and any access with size code 3, changes no register and sets the sticky `err_flag`, which only reset clears.
- R10: `dma_done` clears start/stop and active and sets the interrupt bit.
- R11: `irq` is high exactly when the interrupt bit is set and `irq_en` is high.
- R12: When `dma_done` arrives in the same cycle as a command write, completion wins for start/stop, active and interrupt, and neither `dma_start` nor `dma_abort` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the window |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, registered |
| dma_start | output | 1 | Start request pulse |
| dma_start_ptr | output | 32 | Descriptor table pointer sent with the start pulse |
| dma_abort | output | 1 | Abort request pulse |
| dma_done | input | 1 | Transfer complete from the engine |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
Every access is sampled on one clock edge. The registers it changes, `rd_data`, `err_flag`, and the `dma_start`/`dma_abort` pulses all appear in the cycle right after that edge. `irq` follows the interrupt bit with no further delay. The pulses last one cycle, so the bench checks them at the first falling edge after the write and confirms they are gone one access later. The bench drives inputs on falling edges and reads outputs on the next falling edge, so every result is sampled half a cycle after the edge that produced it.

// File: rtl/bm_chan_regs.sv
module bm_chan_regs #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              dma_start,
  output logic [31:0]       dma_start_ptr,
  output logic              dma_abort,
  input  logic              dma_done,
  input  logic              irq_en,
  output logic              irq,
  output logic              err_flag
);
  localparam int WIN = 8;
  localparam logic [7:0] STS_RST = 8'h60;
  localparam int IW = ADDR_W + 3;

  logic [7:0]  cmd_q, sts_q, cmd_d, sts_d;
  logic [31:0] ptr_q, ptr_d, rd_d;

  wire wr       = acc_valid & acc_write;
  wire size_bad = acc_size == 2'd3;
  wire wr_cmd   = wr && acc_addr == ADDR_W'(0) && acc_size == 2'd0;
  wire wr_sts   = wr && acc_addr == ADDR_W'(2) && acc_size == 2'd0;
  wire wr_ptr   = wr && acc_addr == ADDR_W'(4) && acc_size == 2'd2;
  wire illegal  = acc_valid && (size_bad || (acc_write && !(wr_cmd || wr_sts || wr_ptr)));
  wire start_ev = wr_cmd && !cmd_q[0] &&  acc_wdata[0] && !dma_done;
  wire stop_ev  = wr_cmd &&  cmd_q[0] && !acc_wdata[0] && !dma_done;

  assign irq = sts_q[2] & irq_en;

  always_comb begin
    cmd_d = cmd_q;
    sts_d = sts_q;
    ptr_d = ptr_q;
    if (wr_cmd) begin
      cmd_d = acc_wdata[7:0];
      if (cmd_q[0]) cmd_d[3] = cmd_q[3];
      if (cmd_q[0] != acc_wdata[0]) sts_d[0] = acc_wdata[0];
    end
    if (wr_sts) begin
      sts_d[7:3] = acc_wdata[7:3];
      sts_d[2]   = sts_q[2] & ~acc_wdata[2];
      sts_d[1]   = sts_q[1] & ~acc_wdata[1];
    end
    if (wr_ptr) ptr_d = {acc_wdata[31:2], 2'b00};
    if (dma_done) begin
      cmd_d[0] = 1'b0;
      sts_d[0] = 1'b0;
      sts_d[2] = 1'b1;
    end
  end

  function automatic logic [7:0] win_byte(input logic [IW-1:0] idx,
                                          input logic [7:0] c, input logic [7:0] s,
                                          input logic [31:0] p);
    case (idx)
      IW'(0):  return c;
      IW'(2):  return s;
      IW'(4):  return p[7:0];
      IW'(5):  return p[15:8];
      IW'(6):  return p[23:16];
      IW'(7):  return p[31:24];
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < (1 << acc_size) && (IW'(acc_addr) + IW'(k)) < IW'(WIN))
        rd_d[8*k +: 8] = win_byte(IW'(acc_addr) + IW'(k), cmd_q, sts_q, ptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q         <= '0;
      sts_q         <= STS_RST;
      ptr_q         <= '0;
      rd_data       <= '0;
      dma_start     <= 1'b0;
      dma_abort     <= 1'b0;
      dma_start_ptr <= '0;
      err_flag      <= 1'b0;
    end else begin
      dma_start <= start_ev;
      dma_abort <= stop_ev;
      if (start_ev) dma_start_ptr <= ptr_q;
      if (illegal) err_flag <= 1'b1;
      if (acc_valid && !acc_write) rd_data <= size_bad ? '0 : rd_d;
      if (!illegal) begin
        cmd_q <= cmd_d;
        sts_q <= sts_d;
        ptr_q <= ptr_d;
      end else if (dma_done) begin
        cmd_q[0] <= 1'b0;
        sts_q[0] <= 1'b0;
        sts_q[2] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bm_chan_regs_chk.sv
module bm_chan_regs_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic [7:0]        cmd_q,
  input logic [7:0]        sts_q,
  input logic [31:0]       ptr_q,
  input logic              dma_start,
  input logic [31:0]       dma_start_ptr,
  input logic              dma_abort,
  input logic              dma_done,
  input logic              irq_en,
  input logic              irq,
  input logic              err_flag
);
  // R3
  start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (sts_q[0] && cmd_q[0] && dma_start_ptr == ptr_q));
  // R4
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |-> (!sts_q[0] && !cmd_q[0] && !dma_start));
  // R5
  dir_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[0] |=> $stable(cmd_q[3]));
  // R6
  active_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == ADDR_W'(2) && !dma_done) |=> $stable(sts_q[0]));
  // R8
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[1:0] == 2'b00);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R9
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == 2'd3 && !dma_done) |=> ($stable(cmd_q) && $stable(sts_q) && $stable(ptr_q) && err_flag));
  // R10
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (!cmd_q[0] && !sts_q[0] && sts_q[2]));
  // R11
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (sts_q[2] && irq_en));
  // R12
  done_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (!dma_start && !dma_abort));
endmodule

bind bm_chan_regs bm_chan_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_size(acc_size), .cmd_q(cmd_q), .sts_q(sts_q),
  .ptr_q(ptr_q), .dma_start(dma_start), .dma_start_ptr(dma_start_ptr),
  .dma_abort(dma_abort), .dma_done(dma_done), .irq_en(irq_en), .irq(irq),
  .err_flag(err_flag)
);

// File: tb/bm_chan_regs_tb.sv
`timescale 1ns/1ps
module bm_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data, dma_start_ptr;
  logic        dma_start, dma_abort, dma_done = 1'b0, irq_en = 1'b0, irq, err_flag;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  bm_chan_regs #(.ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .dma_start(dma_start), .dma_start_ptr(dma_start_ptr),
    .dma_abort(dma_abort), .dma_done(dma_done), .irq_en(irq_en), .irq(irq),
    .err_flag(err_flag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; dma_done = 1'b0; acc_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] d, input logic done);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d; dma_done = done;
    @(negedge clk);
    acc_valid = 1'b0; dma_done = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] v);
    acc(1'b0, a, s, '0, 1'b0);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(3'd0, 2'd2, v); check("R2 cmd/sts word", v, 32'h0060_0000);
    rd(3'd4, 2'd2, v); check("R2 ptr", v, 32'h0);
    check("R2 flags", {irq, err_flag, dma_start, dma_abort}, 32'h0);
  endtask

  task automatic t_start_stop();
    logic [31:0] v;
    do_reset();
    acc(1'b1, 3'd4, 2'd2, 32'h1234_5677, 1'b0);
    rd(3'd4, 2'd2, v); check("R8 ptr aligned", v, 32'h1234_5674);
    acc(1'b1, 3'd0, 2'd0, 32'h09, 1'b0);
    check("R3 start pulse", {dma_start, dma_abort}, 32'h2);
    check("R3 start ptr", dma_start_ptr, 32'h1234_5674);
    rd(3'd2, 2'd0, v); check("R3 active", v, 32'h61);
    check("R3 pulse one cycle", dma_start, 32'h0);
    acc(1'b1, 3'd0, 2'd0, 32'h01, 1'b0);
    check("R5 no pulse", {dma_start, dma_abort}, 32'h0);
    rd(3'd0, 2'd0, v); check("R5 dir frozen", v, 32'h09);
    acc(1'b1, 3'd2, 2'd0, 32'h60, 1'b0);
    rd(3'd2, 2'd0, v); check("R6 active kept", v, 32'h61);
    acc(1'b1, 3'd0, 2'd0, 32'h08, 1'b0);
    check("R4 abort pulse", {dma_start, dma_abort}, 32'h1);
    rd(3'd2, 2'd0, v); check("R4 active cleared", v, 32'h60);
    check("R4 pulse one cycle", dma_abort, 32'h0);
    check("R9 legal writes no error", err_flag, 32'h0);
  endtask

  task automatic t_done_irq();
    logic [31:0] v;
    do_reset();
    acc(1'b1, 3'd0, 2'd0, 32'h09, 1'b0);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    rd(3'd0, 2'd0, v); check("R10 start/stop cleared", v, 32'h08);
    rd(3'd2, 2'd0, v); check("R10 int set", v, 32'h64);
    irq_en = 1'b1; #1; check("R11 irq on", irq, 32'h1);
    irq_en = 1'b0; #1; check("R11 irq masked", irq, 32'h0);
    irq_en = 1'b1;
    acc(1'b1, 3'd2, 2'd0, 32'h60, 1'b0);
    rd(3'd2, 2'd0, v); check("R7 write 0 keeps", v, 32'h64);
    acc(1'b1, 3'd2, 2'd0, 32'h66, 1'b0);
    rd(3'd2, 2'd0, v); check("R7 w1c, err not set", v, 32'h60);
    check("R11 irq off", irq, 32'h0);
    irq_en = 1'b0;
  endtask

  task automatic t_priority();
    logic [31:0] v;
    do_reset();
    acc(1'b1, 3'd0, 2'd0, 32'h01, 1'b1);
    check("R12 no start", {dma_start, dma_abort}, 32'h0);
    rd(3'd0, 2'd0, v); check("R12 cmd", v, 32'h00);
    rd(3'd2, 2'd0, v); check("R12 sts", v, 32'h64);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    do_reset();
    acc(1'b1, 3'd4, 2'd2, 32'hA5A5_0000, 1'b0);
    acc(1'b1, 3'd0, 2'd1, 32'h0001, 1'b0);
    check("R9 err set", err_flag, 32'h1);
    check("R9 no start", dma_start, 32'h0);
    rd(3'd0, 2'd0, v); check("R9 cmd unchanged", v, 32'h00);
    acc(1'b1, 3'd4, 2'd0, 32'hFF, 1'b0);
    rd(3'd4, 2'd2, v); check("R9 ptr unchanged", v, 32'hA5A5_0000);
    acc(1'b1, 3'd2, 2'd3, 32'h0, 1'b0);
    rd(3'd2, 2'd0, v); check("R9 size3 sts unchanged", v, 32'h60);
    check("R9 err sticky", err_flag, 32'h1);
  endtask

  task automatic t_reads();
    logic [31:0] v;
    do_reset();
    acc(1'b1, 3'd4, 2'd2, 32'h1234_5674, 1'b0);
    acc(1'b1, 3'd0, 2'd0, 32'h08, 1'b0);
    rd(3'd6, 2'd2, v); check("R1 beyond window", v, 32'h0000_1234);
    rd(3'd1, 2'd0, v); check("R1 reserved byte", v, 32'h0);
    rd(3'd0, 2'd2, v); check("R1 word at 0", v, 32'h0060_0008);
    rd(3'd5, 2'd1, v); check("R1 half at 5", v, 32'h0000_3456);
  endtask

  initial begin
    t_reset();
    t_start_stop();
    t_done_irq();
    t_priority();
    t_illegal();
    t_reads();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule